// File: doc/BRIEF.md
# Bucketed Sample Rate Generator

This block sits at the front of a fast ADC capture path. It runs from a fixed reference clock and derives the enables that pace capture. A raw sample enable fires once every two reference cycles, so a 24 MHz reference gives a 12 MHz raw sample rate. Raw samples are grouped into buckets. Software sets the bucket length with an 8-bit rate value N, and each bucket then holds N+1 samples, from 1 to 256.

Once per bucket, on the bucket's last sample, the block pulses two enables. One advances the capture memory address counter and the other steps the post-trigger counter. These are the only consumers the divider paces. A first-of-bucket strobe marks sample zero of every bucket. A capture-force output passes that strobe to the peak/pit detector when the detector runs in peak or pit mode and the bucket is longer than one sample. This guarantees that the first sample of each bucket is latched and stored.

Writing a new rate value restarts the divider phase and the bucket position at the next reference edge. An active-low synchronous reset clears all state.

Top module: `bucket_rate_gen`

## Requirements
- R1: While `rstN` is low at a clock edge, all counters and the rate value are cleared. Every output reads 0 during reset. After release the rate value is 0, which gives one sample per bucket.
- R2: `sampleEn` is high on every second reference cycle. Counting cycles from 0 after reset release or after a rate write, it is high on the odd-numbered cycles and low on the even-numbered ones.
- R3: With rate value N, a bucket holds N+1 consecutive samples. `addrEn` is high only on the sample whose index within the bucket is N.
- R4: `postTrigEn` is high on exactly the same cycles as `addrEn`.
- R5: `firstStrobe` is high only on the sample whose index within the bucket is 0.
- R6: With N = 0, `firstStrobe` and `addrEn` are both high on every sample cycle.
- R7: When `rateWe` is high at a clock edge, `rateIn` becomes the rate value. The cycle after that edge is cycle 0 of R2, and the next sample is index 0 of a new bucket.
- R8: `captureForce` equals `firstStrobe` when `peakPitMode` is 1 and N is not 0. It is 0 when `peakPitMode` is 0 or when N is 0.
- R9: `addrEn`, `postTrigEn`, `firstStrobe` and `captureForce` are never high on a cycle where `sampleEn` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| rateWe | input | 1 | Load strobe for the rate value |
| rateIn | input | 8 | New rate value N (samples per bucket = N+1) |
| peakPitMode | input | 1 | High when the detector is in peak or pit mode |
| sampleEn | output | 1 | Raw sample enable, half the reference rate |
| addrEn | output | 1 | Capture memory address advance, last sample of a bucket |
| postTrigEn | output | 1 | Post-trigger counter enable, last sample of a bucket |
| firstStrobe | output | 1 | First sample of a bucket |
| captureForce | output | 1 | Forces the detector to store the first sample of a bucket |

## Verification
The hardest case to reach is a bucket-length change at an arbitrary point inside a long bucket, because the old count must be discarded with no stray end pulse. The bench sweeps every rate value from 0 to 255 in turn. Each new value is written while the previous sweep is still partway through a bucket, so every write lands mid-bucket with a different residual count. Each run lasts one bucket plus two samples, so both the wrap and the following first-sample strobe are observed. A reset asserted partway through a sweep shows that the rate value itself returns to one sample per bucket.

// File: rtl/bucket_rate_pkg.sv
package bucket_rate_pkg;
  // Strobes from the control path to the datapath
  typedef struct packed {
    logic sampleTick;  // raw sample slot this cycle
    logic restart;     // reload rate and clear bucket position
  } rate_ctl_t;
endpackage

// File: rtl/bucket_rate_ctrl.sv
module bucket_rate_ctrl
  import bucket_rate_pkg::*;
#(
  parameter int REF_PER_SAMPLE = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rateWe,
  output rate_ctl_t ctl
);
  localparam int PH_W = (REF_PER_SAMPLE > 1) ? $clog2(REF_PER_SAMPLE) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(REF_PER_SAMPLE - 1);

  logic tick;

  generate
    if (REF_PER_SAMPLE > 1) begin : g_div
      logic [PH_W-1:0] phase;
      always_ff @(posedge clk) begin
        if (!rstN || rateWe) phase <= '0;
        else if (phase == PH_LAST) phase <= '0;
        else phase <= phase + 1'b1;
      end
      assign tick = (phase == PH_LAST) && rstN;
    end else begin : g_nodiv
      logic live;
      always_ff @(posedge clk) begin
        if (!rstN || rateWe) live <= 1'b0;
        else live <= 1'b1;
      end
      assign tick = live && rstN;
    end
  endgenerate

  always_comb begin
    ctl.sampleTick = tick;
    ctl.restart    = rateWe;
  end
endmodule

// File: rtl/bucket_rate_dp.sv
module bucket_rate_dp
  import bucket_rate_pkg::*;
#(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rate_ctl_t         ctl,
  input  logic [RATE_W-1:0] rateIn,
  input  logic              peakPitMode,
  output logic              sampleEn,
  output logic              bucketEnd,
  output logic              bucketFirst,
  output logic              forceStore
);
  logic [RATE_W-1:0] rateReg;
  logic [RATE_W-1:0] bucketCnt;
  logic              atEnd;
  logic              atStart;

  assign atEnd   = (bucketCnt == rateReg);
  assign atStart = (bucketCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateReg   <= '0;
      bucketCnt <= '0;
    end else if (ctl.restart) begin
      rateReg   <= rateIn;
      bucketCnt <= '0;
    end else if (ctl.sampleTick) begin
      bucketCnt <= atEnd ? '0 : bucketCnt + 1'b1;
    end
  end

  always_comb begin
    sampleEn    = ctl.sampleTick;
    bucketEnd   = ctl.sampleTick && atEnd;
    bucketFirst = ctl.sampleTick && atStart;
    forceStore  = bucketFirst && peakPitMode && (rateReg != '0);
  end
endmodule

// File: rtl/bucket_rate_gen.sv
module bucket_rate_gen
  import bucket_rate_pkg::*;
#(
  parameter int RATE_W         = 8,
  parameter int REF_PER_SAMPLE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rateWe,
  input  logic [RATE_W-1:0] rateIn,
  input  logic              peakPitMode,
  output logic              sampleEn,
  output logic              addrEn,
  output logic              postTrigEn,
  output logic              firstStrobe,
  output logic              captureForce
);
  rate_ctl_t ctl;
  logic      bucketEnd;

  bucket_rate_ctrl #(.REF_PER_SAMPLE(REF_PER_SAMPLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .rateWe(rateWe), .ctl(ctl)
  );

  bucket_rate_dp #(.RATE_W(RATE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rateIn(rateIn),
    .peakPitMode(peakPitMode), .sampleEn(sampleEn),
    .bucketEnd(bucketEnd), .bucketFirst(firstStrobe),
    .forceStore(captureForce)
  );

  assign addrEn     = bucketEnd;
  assign postTrigEn = bucketEnd;
endmodule

// File: rtl/bucket_rate_checker.sv
module bucket_rate_checker (
  input logic clk,
  input logic rstN,
  input logic rateWe,
  input logic peakPitMode,
  input logic sampleEn,
  input logic addrEn,
  input logic postTrigEn,
  input logic firstStrobe,
  input logic captureForce
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |=> !(sampleEn || addrEn || firstStrobe || captureForce));

  assert_alternate_R2: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |=> !sampleEn);

  assert_wrap_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (addrEn && !rateWe) ##1 !rateWe |=> firstStrobe);

  assert_enables_match_R4: assert property (@(posedge clk) disable iff (!rstN)
    addrEn == postTrigEn);

  assert_restart_phase_R7: assert property (@(posedge clk) disable iff (!rstN)
    rateWe |=> !sampleEn);

  assert_force_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    captureForce |-> (firstStrobe && peakPitMode));

  assert_qualified_R9: assert property (@(posedge clk) disable iff (!rstN)
    (addrEn || firstStrobe || captureForce) |-> sampleEn);
endmodule

bind bucket_rate_gen bucket_rate_checker u_checker (
  .clk(clk), .rstN(rstN), .rateWe(rateWe), .peakPitMode(peakPitMode),
  .sampleEn(sampleEn), .addrEn(addrEn), .postTrigEn(postTrigEn),
  .firstStrobe(firstStrobe), .captureForce(captureForce)
);

// File: tb/bucket_rate_gen_bench.sv
module bucket_rate_gen_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rateWe = 1'b0;
  logic [7:0] rateIn = '0;
  logic       peakPitMode = 1'b0;
  logic       sampleEn, addrEn, postTrigEn, firstStrobe, captureForce;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bucket_rate_gen u_bucket_rate_gen (
    .clk(clk), .rstN(rstN), .rateWe(rateWe), .rateIn(rateIn),
    .peakPitMode(peakPitMode), .sampleEn(sampleEn), .addrEn(addrEn),
    .postTrigEn(postTrigEn), .firstStrobe(firstStrobe),
    .captureForce(captureForce)
  );

  task automatic check(input string tag, input string what,
                       input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  // Compare all outputs with the arithmetic model for cycle c since restart
  task automatic compare(input int c, input int n, input logic m);
    logic expS, expFirst, expLast, expForce;
    int pos;
    expS     = (c % 2) == 1;
    pos      = (c / 2) % (n + 1);
    expFirst = expS && (pos == 0);
    expLast  = expS && (pos == n);
    expForce = expFirst && m && (n != 0);
    check("R2", "sampleEn", sampleEn, expS);
    check(!expS ? "R9" : (n == 0 ? "R6" : "R3"), "addrEn", addrEn, expLast);
    check("R4", "postTrigEn", postTrigEn, expLast);
    check(c == 1 ? "R7" : "R5", "firstStrobe", firstStrobe, expFirst);
    check("R8", "captureForce", captureForce, expForce);
  endtask

  task automatic run(input int n, input logic m, input int len);
    @(negedge clk);
    rateWe = 1'b1;
    rateIn = 8'(n);
    peakPitMode = m;
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      rateWe = 1'b0;
      compare(c, n, m);
    end
  endtask

  initial begin
    // R1: outputs quiet during reset
    repeat (3) begin
      @(negedge clk);
      check("R1", "sampleEn", sampleEn, 1'b0);
      check("R1", "addrEn", addrEn, 1'b0);
      check("R1", "firstStrobe", firstStrobe, 1'b0);
    end
    rstN = 1'b1;
    peakPitMode = 1'b1;
    for (int c = 0; c < 8; c++) begin
      if (c > 0) @(negedge clk);
      compare(c, 0, 1'b1);  // R1: rate value cleared to 0
    end
    // Exhaustive sweep of every rate value, each write landing mid-bucket
    for (int n = 0; n < 256; n++) begin
      run(n, (n % 3) != 0, 2 * (n + 1) + 4 + (n % 5));
      if (n < 8) run(n, 1'b1, 4 * (n + 1) + 3);
    end
    // Mid-run reset returns the rate value to 0 (R1)
    run(9, 1'b1, 7);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R1", "captureForce", captureForce, 1'b0);
    check("R1", "sampleEn", sampleEn, 1'b0);
    rstN = 1'b1;
    for (int c = 0; c < 10; c++) begin
      if (c > 0) @(negedge clk);
      compare(c, 0, 1'b1);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule